// File: doc/BRIEF.md
# Serial ADC Read Controller

This block is the host side of a link to a 10-bit successive-approximation converter that talks over three wires: an active-low select, a serial clock and a single data return line. A user asks for a conversion by pulsing `start_i` while `ready_o` is high. The controller pulls select low, produces a serial clock divided down from the system clock, and samples the returned data on each rising serial-clock edge. The converter changes its data on falling edges. The first two rising edges of a frame fall in the converter's acquisition window and are discarded. The third carries a null bit that must read low. The result bits follow, most significant first.

Three read modes are offered, and the mode is latched at start. A full read collects all ten result bits. A short read stops after the eight upper bits, which saves two serial clocks per conversion, and returns the value with its two lowest bits forced to zero. An echo-checked read keeps clocking after the last result bit to collect the bit-reversed repeat of bits 1 to 9, and it flags any disagreement with the first word. Select is then raised. One system cycle later the result is presented with a single-cycle `done_o` pulse and its two error flags. Select then stays high for at least one serial-clock period before the controller will accept another start.

Top module: `adc_serial_reader`

## Requirements
- R1: While reset is held, and directly after it, `cs_n_o` is high, `sclk_o` is low, `done_o` is low and `ready_o` is high.
- R2: Each serial-clock half period lasts DIV+1 system cycles, where DIV is the value of `div_i` latched at start. The first rising edge comes DIV+1 cycles after `cs_n_o` falls, and the clock idles low whenever select is high.
- R3: The number of rising serial-clock edges in a frame depends on the latched `mode_i`. Code 2'b00 (full) gives 13, code 2'b01 (short) gives 11, code 2'b10 (echo check) gives 22, and code 2'b11 behaves as full with 13.
- R4: In full mode the data line is sampled on rising edges. The 4th to 13th rising edges give result bits 9 down to 0, and `result_o` carries that value.
- R5: In short mode the 4th to 11th rising edges give result bits 9 down to 2, and `result_o[1:0]` is zero.
- R6: `frame_err_o` is high with `done_o` exactly when the bit sampled on the 3rd rising edge (the null bit) was high.
- R7: In echo-check mode the 14th to 22nd rising edges carry bits 1 to 9 in that order. `echo_err_o` is high with `done_o` exactly when any of them differs from the first word. In every other mode `echo_err_o` is low.
- R8: `done_o` is high for exactly one system cycle, and that cycle is the one right after the cycle in which `cs_n_o` rises.
- R9: `cs_n_o` stays high for at least 2*(DIV+1) system cycles between frames. `ready_o` is high only while select is high. A `start_i` given while `ready_o` is low starts no frame, and no frame starts without `start_i`.
- R10: Changes on `mode_i` and `div_i` after the start cycle have no effect on the frame in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a conversion, taken while `ready_o` is high |
| mode_i | input | 2 | Read mode: 00 full, 01 short, 10 echo check, 11 full |
| div_i | input | DIV_W | Serial-clock divider; half period is DIV+1 system cycles |
| ready_o | output | 1 | Controller idle and able to accept `start_i` |
| done_o | output | 1 | One-cycle pulse: result and flags valid |
| result_o | output | RES_W | Assembled conversion value |
| frame_err_o | output | 1 | Null bit read high in the last frame |
| echo_err_o | output | 1 | Echo word disagreed with the first word |
| cs_n_o | output | 1 | Active-low converter select |
| sclk_o | output | 1 | Serial clock to the converter |
| sdo_i | input | 1 | Serial data returned by the converter |

## Verification
The case hardest to reach from the ports is a frame whose echo bits disagree with the first word, because a real converter never produces one. The bench's converter model flips a single echo bit on request, and it can drive the null bit high, so both error paths are reached on purpose in every mode. The model also drives the data line high during the acquisition window, so a controller that samples one edge early reads a false null error. A start pulse together with changed mode and divider is issued in the middle of a frame, to show that the latched settings and the busy interlock hold.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [1:0] {
    RD_FULL  = 2'b00,
    RD_SHORT = 2'b01,
    RD_ECHO  = 2'b10,
    RD_ALT   = 2'b11
  } rd_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_XFER,
    ST_DONE,
    ST_GAP
  } rd_state_e;

  // Rising serial-clock edges in one frame: acquisition edges, null bit, payload.
  function automatic int unsigned frame_edges(rd_mode_e m, int unsigned pre,
                                              int unsigned res_w, int unsigned keep_w);
    case (m)
      RD_SHORT: return pre + 1 + keep_w;
      RD_ECHO:  return pre + 1 + 2 * res_w - 1;
      default:  return pre + 1 + res_w;
    endcase
  endfunction

endpackage

// File: rtl/adc_rd_tick.sv
module adc_rd_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + DIV_W'(1);
  end

endmodule

// File: rtl/adc_rd_fsm.sv
module adc_rd_fsm
  import adc_rd_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int RES_W  = 10,
  parameter int KEEP_W = 8,
  parameter int PRE    = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 start_i,
  input  logic [1:0]                           mode_i,
  input  logic [DIV_W-1:0]                     div_i,
  input  logic                                 tick_i,
  output logic                                 run_o,
  output logic                                 cs_n_o,
  output logic                                 sclk_o,
  output logic                                 ready_o,
  output logic                                 rise_o,
  output logic [$clog2(PRE+2*RES_W+1)-1:0]     idx_o,
  output logic                                 fin_o,
  output logic [1:0]                           mode_o,
  output logic [DIV_W-1:0]                     div_o
);

  localparam int IDX_W = $clog2(PRE + 2 * RES_W + 1);

  rd_state_e        state_q;
  logic [IDX_W-1:0] idx_q;
  logic             sclk_q, cs_n_q, gap_q;
  logic [1:0]       mode_q;
  logic [DIV_W-1:0] div_q;
  logic             last_w;

  assign last_w  = (idx_q == IDX_W'(frame_edges(rd_mode_e'(mode_q), PRE, RES_W, KEEP_W)));
  assign rise_o  = (state_q == ST_XFER) && tick_i && !sclk_q;
  assign idx_o   = idx_q + IDX_W'(1);
  assign run_o   = (state_q == ST_XFER) || (state_q == ST_GAP);
  assign fin_o   = (state_q == ST_DONE);
  assign ready_o = (state_q == ST_IDLE);
  assign cs_n_o  = cs_n_q;
  assign sclk_o  = sclk_q;
  assign mode_o  = mode_q;
  assign div_o   = div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      sclk_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      gap_q   <= 1'b0;
      mode_q  <= RD_FULL;
      div_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          mode_q  <= mode_i;
          div_q   <= div_i;
          cs_n_q  <= 1'b0;
          sclk_q  <= 1'b0;
          idx_q   <= '0;
          state_q <= ST_XFER;
        end
        ST_XFER: if (tick_i) begin
          if (!sclk_q) begin
            sclk_q <= 1'b1;
            idx_q  <= idx_q + IDX_W'(1);
          end else if (last_w) begin
            sclk_q  <= 1'b0;
            cs_n_q  <= 1'b1;
            state_q <= ST_DONE;
          end else begin
            sclk_q <= 1'b0;
          end
        end
        ST_DONE: begin
          gap_q   <= 1'b0;
          state_q <= ST_GAP;
        end
        ST_GAP: if (tick_i) begin
          if (gap_q) state_q <= ST_IDLE;
          else       gap_q   <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/adc_rd_capture.sv
module adc_rd_capture
  import adc_rd_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int KEEP_W = 8,
  parameter int PRE    = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              rise_i,
  input  logic [$clog2(PRE+2*RES_W+1)-1:0]  idx_i,
  input  logic                              sdo_i,
  input  logic                              fin_i,
  input  logic [1:0]                        mode_i,
  output logic [RES_W-1:0]                  result_o,
  output logic                              done_o,
  output logic                              frame_err_o,
  output logic                              echo_err_o
);

  localparam int IDX_W    = $clog2(PRE + 2 * RES_W + 1);
  localparam int NULL_IDX = PRE + 1;
  localparam int MSB_LAST = PRE + 1 + RES_W;
  localparam int DROP_W   = RES_W - KEEP_W;

  logic [RES_W-1:0] word_q;
  logic [RES_W-2:0] echo_q;
  logic             null_q;
  logic             in_word_w, in_echo_w;

  // Short reads hold their bits in the low KEEP_W positions of the shifter.
  function automatic logic [RES_W-1:0] place_result(logic [1:0] m, logic [RES_W-1:0] w);
    if (rd_mode_e'(m) == RD_SHORT) return {w[KEEP_W-1:0], {DROP_W{1'b0}}};
    return w;
  endfunction

  // The echo word arrives LSB-side first, so it lines up with word[RES_W-1:1].
  function automatic logic echo_mismatch(logic [1:0] m, logic [RES_W-1:0] w,
                                         logic [RES_W-2:0] e);
    return (rd_mode_e'(m) == RD_ECHO) && (e != w[RES_W-1:1]);
  endfunction

  assign in_word_w = (idx_i > IDX_W'(NULL_IDX)) && (idx_i <= IDX_W'(MSB_LAST));
  assign in_echo_w = (idx_i > IDX_W'(MSB_LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q      <= '0;
      echo_q      <= '0;
      null_q      <= 1'b0;
      result_o    <= '0;
      done_o      <= 1'b0;
      frame_err_o <= 1'b0;
      echo_err_o  <= 1'b0;
    end else begin
      done_o <= fin_i;
      if (rise_i) begin
        if (idx_i == IDX_W'(NULL_IDX)) null_q <= sdo_i;
        if (in_word_w)                 word_q <= {word_q[RES_W-2:0], sdo_i};
        if (in_echo_w)                 echo_q <= {sdo_i, echo_q[RES_W-2:1]};
      end
      if (fin_i) begin
        result_o    <= place_result(mode_i, word_q);
        frame_err_o <= null_q;
        echo_err_o  <= echo_mismatch(mode_i, word_q, echo_q);
      end
    end
  end

endmodule

// File: rtl/adc_serial_reader.sv
module adc_serial_reader
  import adc_rd_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int RES_W  = 10,
  parameter int KEEP_W = 8,
  parameter int PRE    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       mode_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             ready_o,
  output logic             done_o,
  output logic [RES_W-1:0] result_o,
  output logic             frame_err_o,
  output logic             echo_err_o,
  output logic             cs_n_o,
  output logic             sclk_o,
  input  logic             sdo_i
);

  localparam int IDX_W = $clog2(PRE + 2 * RES_W + 1);

  logic             tick_w, run_w, rise_w, fin_w;
  logic [IDX_W-1:0] idx_w;
  logic [1:0]       mode_q_w;
  logic [DIV_W-1:0] div_q_w;

  adc_rd_tick #(.DIV_W(DIV_W)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run_w),
    .div_i  (div_q_w),
    .tick_o (tick_w)
  );

  adc_rd_fsm #(.DIV_W(DIV_W), .RES_W(RES_W), .KEEP_W(KEEP_W), .PRE(PRE)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .mode_i  (mode_i),
    .div_i   (div_i),
    .tick_i  (tick_w),
    .run_o   (run_w),
    .cs_n_o  (cs_n_o),
    .sclk_o  (sclk_o),
    .ready_o (ready_o),
    .rise_o  (rise_w),
    .idx_o   (idx_w),
    .fin_o   (fin_w),
    .mode_o  (mode_q_w),
    .div_o   (div_q_w)
  );

  adc_rd_capture #(.RES_W(RES_W), .KEEP_W(KEEP_W), .PRE(PRE)) u_cap (
    .clk         (clk),
    .rst_n       (rst_n),
    .rise_i      (rise_w),
    .idx_i       (idx_w),
    .sdo_i       (sdo_i),
    .fin_i       (fin_w),
    .mode_i      (mode_q_w),
    .result_o    (result_o),
    .done_o      (done_o),
    .frame_err_o (frame_err_o),
    .echo_err_o  (echo_err_o)
  );

endmodule

// File: rtl/adc_serial_reader_chk.sv
module adc_serial_reader_chk
  import adc_rd_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int KEEP_W = 8,
  parameter int PRE    = 2
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             cs_n_o,
  input logic                             sclk_o,
  input logic                             ready_o,
  input logic                             done_o,
  input logic [RES_W-1:0]                 result_o,
  input logic                             echo_err_o,
  input logic                             tick_w,
  input logic                             rise_w,
  input logic [$clog2(PRE+2*RES_W+1)-1:0] idx_w,
  input logic [1:0]                       mode_q_w
);

  localparam int IDX_W = $clog2(PRE + 2 * RES_W + 1);

  assert_clock_idles_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sclk_o);

  assert_clock_moves_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_w |=> $stable(sclk_o));

  assert_edge_index_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rise_w |-> (idx_w <= IDX_W'(frame_edges(rd_mode_e'(mode_q_w), PRE, RES_W, KEEP_W))));

  assert_short_low_bits_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && mode_q_w == 2'b01) |-> (result_o[RES_W-KEEP_W-1:0] == '0));

  assert_echo_flag_only_echo_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && mode_q_w != 2'b10) |-> !echo_err_o);

  assert_done_after_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_o) |=> done_o);

  assert_done_single_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_ready_select_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> cs_n_o);

  assert_frame_starts_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> $past(ready_o));

endmodule

bind adc_serial_reader adc_serial_reader_chk #(.RES_W(RES_W), .KEEP_W(KEEP_W), .PRE(PRE)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_n_o     (cs_n_o),
  .sclk_o     (sclk_o),
  .ready_o    (ready_o),
  .done_o     (done_o),
  .result_o   (result_o),
  .echo_err_o (echo_err_o),
  .tick_w     (tick_w),
  .rise_w     (rise_w),
  .idx_w      (idx_w),
  .mode_q_w   (mode_q_w)
);

// File: tb/adc_serial_reader_bench.sv
module adc_serial_reader_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DIV_W      = 8;
  localparam int RES_W      = 10;
  localparam int LIMIT      = 190000;

  logic             clk, rst_n, start_i, sdo_i;
  logic [1:0]       mode_i;
  logic [DIV_W-1:0] div_i;
  logic             ready_o, done_o, frame_err_o, echo_err_o, cs_n_o, sclk_o;
  logic [RES_W-1:0] result_o;

  adc_serial_reader u_adc_serial_reader (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i), .div_i(div_i),
    .ready_o(ready_o), .done_o(done_o), .result_o(result_o),
    .frame_err_o(frame_err_o), .echo_err_o(echo_err_o),
    .cs_n_o(cs_n_o), .sclk_o(sclk_o), .sdo_i(sdo_i)
  );

  int n_chk = 0;
  int n_bad = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Converter model: data changes on falling serial-clock edges.
  logic [RES_W-1:0] m_val = '0;
  bit m_bad_null = 0, m_bad_echo = 0;
  int fcnt = 0;

  function automatic logic model_bit(int f);
    logic b;
    if (f == 2) return m_bad_null;
    if (f >= 3 && f <= 12) return m_val[12-f];
    if (f >= 13 && f <= 21) begin
      b = m_val[f-12];
      return (m_bad_echo && f == 15) ? ~b : b;
    end
    if (f < 2) return 1'b1;
    return 1'b0;
  endfunction

  initial sdo_i = 1'b1;
  always @(negedge sclk_o or posedge cs_n_o) begin
    if (cs_n_o !== 1'b0) begin
      fcnt  = 0;
      sdo_i = 1'b1;
    end else begin
      fcnt++;
      sdo_i = model_bit(fcnt);
    end
  end

  // Port monitor, sampled on the falling system-clock edge.
  int cyc = 0, cs_fall_cyc = 0, cs_rise_cyc = 0, last_tog = 0;
  int rises = 0, hp_bad = 0, done_cyc = 0, done_len = 0, frames = 0, gap_len = 0;
  int exp_half = 1;
  logic cs_prev = 1'b1, sclk_prev = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (cs_prev && !cs_n_o) begin
        gap_len = cyc - cs_rise_cyc;
        cs_fall_cyc = cyc;
        last_tog = cyc;
        rises = 0;
        hp_bad = 0;
        done_len = 0;
        frames++;
      end
      if (sclk_o != sclk_prev) begin
        if (cyc - last_tog != exp_half) hp_bad++;
        last_tog = cyc;
        if (sclk_o) rises++;
      end
      if (!cs_prev && cs_n_o) cs_rise_cyc = cyc;
      if (done_o) begin
        if (done_len == 0) done_cyc = cyc;
        done_len++;
      end
      cs_prev = cs_n_o;
      sclk_prev = sclk_o;
    end
  end

  function automatic int exp_edges(logic [1:0] m);
    case (m)
      2'b01:   return 3 + 8;
      2'b10:   return 3 + 10 + 9;
      default: return 3 + 10;
    endcase
  endfunction

  int prev_half = 0;
  int exp_frames = 0;

  task automatic do_frame(input logic [1:0] mode, input int d, input logic [RES_W-1:0] v,
                          input bit bn, input bit be, input bit disturb);
    logic [RES_W-1:0] exp_res;
    @(negedge clk);
    while (!ready_o) @(negedge clk);
    m_val = v; m_bad_null = bn; m_bad_echo = be; exp_half = d + 1;
    mode_i = mode; div_i = DIV_W'(d); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    exp_frames++;
    if (disturb) begin
      mode_i = ~mode; div_i = DIV_W'(d + 3);
      @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (!done_o) @(negedge clk);
    exp_res = (mode == 2'b01) ? (v & 10'h3FC) : v;
    chk(result_o == exp_res, (mode == 2'b01) ? "R5 short result" : "R4 result (R10)",
        int'(result_o), int'(exp_res));
    chk(frame_err_o == bn, "R6 null-bit flag", int'(frame_err_o), int'(bn));
    chk(echo_err_o == (be && mode == 2'b10), "R7 echo flag", int'(echo_err_o),
        int'(be && mode == 2'b10));
    @(negedge clk);
    @(negedge clk);
    chk(rises == exp_edges(mode), "R3 rising edges per frame", rises, exp_edges(mode));
    chk(hp_bad == 0, "R2 half-period length", hp_bad, 0);
    chk(done_cyc == cs_rise_cyc + 1, "R8 done after select rise", done_cyc - cs_rise_cyc, 1);
    chk(done_len == 1, "R8 done width", done_len, 1);
    chk(frames == exp_frames, "R9 frame count (busy start ignored)", frames, exp_frames);
    if (prev_half != 0)
      chk(gap_len >= 2 * prev_half, "R9 select-high gap", gap_len, 2 * prev_half);
    prev_half = d + 1;
  endtask

  initial begin
    #(CLK_PERIOD * LIMIT);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", LIMIT, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; mode_i = 2'b00; div_i = '0;
    repeat (3) @(negedge clk);
    chk(cs_n_o && !sclk_o && !done_o && ready_o, "R1 state in reset",
        {cs_n_o, sclk_o, done_o, ready_o}, 4'b1001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n_o && !sclk_o && !done_o && ready_o, "R1 state after reset",
        {cs_n_o, sclk_o, done_o, ready_o}, 4'b1001);

    for (int v = 0; v < 1024; v++) do_frame(2'b00, 0, RES_W'(v), 0, 0, 0);   // R4
    for (int v = 0; v < 1024; v++) do_frame(2'b01, 0, RES_W'(v), 0, 0, 0);   // R5
    for (int v = 0; v < 1024; v += 37) begin                                  // R7
      do_frame(2'b10, 1, RES_W'(v), 0, 0, 0);
      do_frame(2'b10, 1, RES_W'(v), 0, 1, 0);
    end
    for (int v = 0; v < 1024; v += 101) begin                                 // R3 alt code
      do_frame(2'b11, 0, RES_W'(v), 0, 0, 0);
      do_frame(2'b00, 0, RES_W'(v), 0, 1, 0);                                 // R7 non-echo
    end
    for (int d = 0; d < 6; d++) begin                                         // R2
      do_frame(2'b00, d, 10'h2AA, 0, 0, 0);
      do_frame(2'b01, d, 10'h155, 0, 0, 0);
    end
    for (int m = 0; m < 4; m++) do_frame(2'(m), 2, 10'h3C5, 1, 0, 0);        // R6
    for (int m = 0; m < 3; m++) do_frame(2'(m), 1, 10'h19B, 0, 0, 1);        // R9, R10

    repeat (60) @(negedge clk);
    chk(frames == exp_frames, "R9 no frame without start", frames, exp_frames);
    chk(cs_n_o && ready_o, "R9 idle select high", {cs_n_o, ready_o}, 2'b11);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule